// File: doc/BRIEF.md
# Lockable Board Control Register Bank

This block is a bank of control and status words for a development board. It sits on a simple 32-bit peripheral bus that uses a setup phase and then an access phase. Software reads an identification word and two fixed-value words, and it drives board LEDs. It keeps two flag words, each with one address that sets bits and another that clears them. One of the two flag words survives the block's reset. The block also reads back live card-slot status and a free-running tick count, and it holds a display-control word.

The identification word is a build-time parameter. Bits 27:16 of that word give a board type, and the board type decides three things: which display-control bits software can write, whether the reset-control word can be written, and which bit of a reset-control write asks for a system reset. Writes to reset control only take effect after software has stored the unlock key in the key word. A qualifying write produces a one-cycle reset-request pulse. On one board type, the low two bits of each display-control write also drive a 2-bit display-format select output.

Top module: `sysreg_bank`

## Requirements
- R1: Offset 0x00 reads the ID_VALUE parameter and offset 0x84 reads the PROC_ID parameter. Offset 0x44 always reads 0x00000001 and offset 0x88 always reads 0xFF000000. Any offset not listed in R1 to R14 reads zero and ignores writes, and writes to the fixed-value words have no effect.
- R2: A write to the key word at 0x20 stores 0xA05F when the data is exactly 0x0000A05F. For any other data it stores bits 15:0 with bit 15 forced to 0. The key word reads back zero-extended. The bank is unlocked only while the stored key equals 0xA05F.
- R3: A write to 0x30 ORs the data into the user flags, and reading 0x30 returns them. A write to 0x34 clears every flag bit that is 1 in the data.
- R4: The retained flags behave the same way at 0x38 (read and set) and 0x3C (clear). The block's reset does not change them.
- R5: The synchronous active-low reset clears the LED word, the key, the user flags and the reset-control word. It returns the display word to its reset value and the display select to 0.
- R6: Offset 0x08 stores the low LED_W bits of the written data. It reads them back zero-extended and drives them on led_out.
- R7: The board type comes from ID bits 27:16, with these codes: A = 0x100, B = 0x140, C = 0x178 or 0x182, D = 0x190. A write to reset control at 0x40 is stored only while unlocked and only on types A and C. Type D reads 0x40 as zero.
- R8: A stored reset-control write raises reset_req for exactly one cycle, starting at the clock edge that completes the write. This happens on type A when data bit 8 is 1 and on type C when data bit 2 is 1.
- R9: The display word at 0x50 resets to 0x00001F00 on every type except D. On type D it reads zero and ignores writes.
- R10: On types A and B, bits 13:8 of the display word keep their value on a write and every other bit takes the written data.
- R11: On type A, a write to 0x50 loads data bits 1:0 into disp_mux. On every other type, disp_mux stays 0.
- R12: On type C, a display write keeps bit 7 and loads every other bit from the data.
- R13: Offset 0x48 reads card_present in bit 0. It reads card_wprot in bit 2 on types A and B, and in bit 1 on other types. Writes to 0x48 are ignored.
- R14: Offset 0x5C reads a counter of TICK_HZ ticks derived from a CLK_HZ bus clock. With the default parameters it advances by exactly 24 across any 100 bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset of the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| card_present | input | 1 | Card-detect status |
| card_wprot | input | 1 | Card write-protect status |
| led_out | output | LED_W | LED drive |
| reset_req | output | 1 | One-cycle system reset request |
| disp_mux | output | 2 | Display-format select |

## Verification
Read data is combinational from the current state, so the result of a write becomes visible in the access phase of the very next transfer. The bench therefore compares each read half a cycle into its access phase. reset_req and disp_mux are registered by the edge that completes the write: they are checked at the falling edge right after the write transfer, and reset_req is checked low again one cycle later. The tick counter is sampled at the same phase of two reads that start exactly 100 cycles apart, so the expected difference is exact.

// File: rtl/sysreg_pkg.sv
// Shared types and constants for the board control register bank.
// Assumes byte offsets on word boundaries and a 32-bit data path.
package sysreg_pkg;

    typedef enum logic [2:0] {
        BRD_A,
        BRD_B,
        BRD_C,
        BRD_D,
        BRD_OTHER
    } board_e;

    localparam int OFF_ID     = 'h00;
    localparam int OFF_LED    = 'h08;
    localparam int OFF_KEY    = 'h20;
    localparam int OFF_FSET   = 'h30;
    localparam int OFF_FCLR   = 'h34;
    localparam int OFF_NSET   = 'h38;
    localparam int OFF_NCLR   = 'h3C;
    localparam int OFF_RSTCTL = 'h40;
    localparam int OFF_ONE    = 'h44;
    localparam int OFF_CARD   = 'h48;
    localparam int OFF_DISP   = 'h50;
    localparam int OFF_TICK   = 'h5C;
    localparam int OFF_PROC   = 'h84;
    localparam int OFF_FIXED  = 'h88;

    localparam logic [15:0] KEY_OPEN = 16'hA05F;

    // Map the board-type field (ID bits 27:16) to a variant.
    function automatic board_e board_of(input logic [31:0] id);
        case (id[27:16])
            12'h100:         return BRD_A;
            12'h140:         return BRD_B;
            12'h178, 12'h182: return BRD_C;
            12'h190:         return BRD_D;
            default:         return BRD_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/sysreg_lock.sv
// Key word that guards reset control.
// Stores the exact key value, or any other value with bit 15 forced low.
// Assumes wr_en is a single-cycle qualified bus write.
module sysreg_lock
    import sysreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [15:0] key_q,
    output logic        unlocked
);

    // Capture the key, clearing bit 15 unless the full word is the key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (wr_en)
            key_q <= (wdata == {16'h0, KEY_OPEN}) ? KEY_OPEN
                                                  : {1'b0, wdata[14:0]};
    end

    assign unlocked = (key_q == KEY_OPEN);

    // R2
    property key_nonmatch_p;
        @(posedge clk) disable iff (!rst_n)
            (wr_en && wdata != {16'h0, KEY_OPEN}) |=> !key_q[15] && !unlocked;
    endproperty
    key_nonmatch_chk: assert property (key_nonmatch_p);

endmodule

// File: rtl/sysreg_flags.sv
// Flag word with separate set and clear write strobes.
// CLEAR_ON_RESET = 0 gives a word that the block reset leaves untouched.
// Assumes set_en and clr_en are never active together.
module sysreg_flags #(
    parameter int W              = 32,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    // Next value: OR on set, AND-NOT on clear.
    always_comb begin
        q_next = q;
        if (set_en)
            q_next = q | wdata;
        else if (clr_en)
            q_next = q & ~wdata;
    end

    generate
        if (CLEAR_ON_RESET) begin : g_rst
            // Resettable flag storage.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= q_next;
            end
        end else begin : g_keep
            // Retained flag storage, not touched by reset.
            always_ff @(posedge clk) begin
                q <= q_next;
            end
        end
    endgenerate

    // R3
    property set_bits_p;
        @(posedge clk) disable iff (!rst_n)
            set_en |=> ((q & $past(wdata)) == $past(wdata));
    endproperty
    set_bits_chk: assert property (set_bits_p);

    // R4
    property clr_bits_p;
        @(posedge clk) disable iff (!rst_n)
            clr_en |=> ((q & $past(wdata)) == '0);
    endproperty
    clr_bits_chk: assert property (clr_bits_p);

endmodule

// File: rtl/sysreg_disp.sv
// Display-control word whose writable bits depend on the board variant,
// plus the 2-bit format select that only variant A drives.
// Assumes wr_en is a single-cycle qualified bus write.
module sysreg_disp
    import sysreg_pkg::*;
#(
    parameter board_e BOARD = BRD_A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] q,
    output logic [1:0]  mux
);

    localparam logic [31:0] KEEP =
        (BOARD == BRD_A || BOARD == BRD_B) ? 32'h0000_3F00 :
        (BOARD == BRD_C)                   ? 32'h0000_0080 :
                                             32'hFFFF_FFFF;
    localparam logic [31:0] RST_VAL = (BOARD == BRD_D) ? 32'h0 : 32'h0000_1F00;

    // Merge kept bits with written data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (wr_en)
            q <= (q & KEEP) | (wdata & ~KEEP);
    end

    generate
        if (BOARD == BRD_A) begin : g_mux
            // Format select follows the low bits of each write.
            always_ff @(posedge clk) begin
                if (!rst_n)     mux <= 2'b00;
                else if (wr_en) mux <= wdata[1:0];
            end

            // R11
            property mux_load_p;
                @(posedge clk) disable iff (!rst_n)
                    wr_en |=> (mux == $past(wdata[1:0]));
            endproperty
            mux_load_chk: assert property (mux_load_p);
        end else begin : g_nomux
            assign mux = 2'b00;
        end
    endgenerate

    // R10
    property kept_bits_p;
        @(posedge clk) disable iff (!rst_n)
            wr_en |=> (((q ^ $past(q)) & KEEP) == '0);
    endproperty
    kept_bits_chk: assert property (kept_bits_p);

endmodule

// File: rtl/sysreg_ticker.sv
// Free-running count of TICK_HZ ticks derived from a CLK_HZ clock
// with a phase accumulator. Assumes TICK_HZ <= CLK_HZ.
module sysreg_ticker #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 24_000_000,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = acc + STEP;

    // Advance the phase and emit at most one tick per bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            count <= '0;
        end else if (acc_sum >= WRAP) begin
            acc   <= acc_sum - WRAP;
            count <= count + 1'b1;
        end else begin
            acc   <= acc_sum;
        end
    end

    // R14
    property tick_step_p;
        @(posedge clk) disable iff (!rst_n)
            ##1 (count == $past(count) || count == $past(count) + 1'b1);
    endproperty
    tick_step_chk: assert property (tick_step_p);

endmodule

// File: rtl/sysreg_bank.sv
// Board control register bank on a two-phase 32-bit peripheral bus.
// Decodes byte offsets, owns the LED and reset-control words, issues the
// reset-request pulse and forms the combinational read data.
// Assumes writes complete in the access phase (psel & penable & pwrite).
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h1100_0A01,
    parameter logic [31:0] PROC_ID  = 32'h0C00_0191,
    parameter int          ADDR_W   = 12,
    parameter int          LED_W    = 8,
    parameter int          CLK_HZ   = 100_000_000,
    parameter int          TICK_HZ  = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              card_present,
    input  logic              card_wprot,
    output logic [LED_W-1:0]  led_out,
    output logic              reset_req,
    output logic [1:0]        disp_mux
);

    localparam board_e BOARD      = board_of(ID_VALUE);
    localparam bit     RST_WRITE  = (BOARD == BRD_A) || (BOARD == BRD_C);
    localparam int     TRIG_BIT   = (BOARD == BRD_A) ? 8 : 2;
    localparam int     WP_BIT     = (BOARD == BRD_A || BOARD == BRD_B) ? 2 : 1;

    logic        wr;
    logic        wr_led, wr_key, wr_fset, wr_fclr, wr_nset, wr_nclr;
    logic        wr_rst, wr_disp;
    logic        rst_take;
    logic [15:0] key_q;
    logic        unlocked;
    logic [31:0] flags_q, nvflags_q, disp_q, tick_q, rst_level;
    logic [LED_W-1:0] led_q;
    logic [31:0] card_word;

    // Qualified write strobes per offset.
    always_comb begin
        wr      = psel && penable && pwrite;
        wr_led  = wr && (paddr == ADDR_W'(OFF_LED));
        wr_key  = wr && (paddr == ADDR_W'(OFF_KEY));
        wr_fset = wr && (paddr == ADDR_W'(OFF_FSET));
        wr_fclr = wr && (paddr == ADDR_W'(OFF_FCLR));
        wr_nset = wr && (paddr == ADDR_W'(OFF_NSET));
        wr_nclr = wr && (paddr == ADDR_W'(OFF_NCLR));
        wr_rst  = wr && (paddr == ADDR_W'(OFF_RSTCTL));
        wr_disp = wr && (paddr == ADDR_W'(OFF_DISP));
    end

    assign rst_take = wr_rst && unlocked && RST_WRITE;

    sysreg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_key),
        .wdata    (pwdata),
        .key_q    (key_q),
        .unlocked (unlocked)
    );

    sysreg_flags #(.W(32), .CLEAR_ON_RESET(1'b1)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_fset),
        .clr_en (wr_fclr),
        .wdata  (pwdata),
        .q      (flags_q)
    );

    sysreg_flags #(.W(32), .CLEAR_ON_RESET(1'b0)) u_nvflags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_nset),
        .clr_en (wr_nclr),
        .wdata  (pwdata),
        .q      (nvflags_q)
    );

    sysreg_disp #(.BOARD(BOARD)) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_disp),
        .wdata (pwdata),
        .q     (disp_q),
        .mux   (disp_mux)
    );

    sysreg_ticker #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tick_q)
    );

    // LED word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      led_q <= '0;
        else if (wr_led) led_q <= pwdata[LED_W-1:0];
    end

    assign led_out = led_q;

    // Reset-control word and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_level <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= rst_take && pwdata[TRIG_BIT];
            if (rst_take)
                rst_level <= pwdata;
        end
    end

    assign card_word = 32'(card_present) | (32'(card_wprot) << WP_BIT);

    // Read data for the addressed offset.
    always_comb begin
        case (paddr)
            ADDR_W'(OFF_ID):     prdata = ID_VALUE;
            ADDR_W'(OFF_LED):    prdata = 32'(led_q);
            ADDR_W'(OFF_KEY):    prdata = 32'(key_q);
            ADDR_W'(OFF_FSET):   prdata = flags_q;
            ADDR_W'(OFF_NSET):   prdata = nvflags_q;
            ADDR_W'(OFF_RSTCTL): prdata = (BOARD == BRD_D) ? 32'h0 : rst_level;
            ADDR_W'(OFF_ONE):    prdata = 32'h0000_0001;
            ADDR_W'(OFF_CARD):   prdata = card_word;
            ADDR_W'(OFF_DISP):   prdata = disp_q;
            ADDR_W'(OFF_TICK):   prdata = tick_q;
            ADDR_W'(OFF_PROC):   prdata = PROC_ID;
            ADDR_W'(OFF_FIXED):  prdata = 32'hFF00_0000;
            default:             prdata = 32'h0;
        endcase
    end

    // R8
    property req_single_p;
        @(posedge clk) disable iff (!rst_n)
            reset_req |=> !reset_req;
    endproperty
    req_single_chk: assert property (req_single_p);

    // R7
    property req_needs_key_p;
        @(posedge clk) disable iff (!rst_n)
            reset_req |-> $past(unlocked && wr_rst);
    endproperty
    req_needs_key_chk: assert property (req_needs_key_p);

    // R5
    property led_reset_p;
        @(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (led_out == '0);
    endproperty
    led_reset_chk: assert property (led_reset_p);

endmodule

// File: tb/sim_sysreg_bank.sv
// Scoreboard bench: four instances of the bank, one per board variant,
// share a bus. Read tasks queue expected words; a monitor compares them.
module sim_sysreg_bank;

    localparam logic [31:0] ID_A = 32'h1100_0A01;
    localparam logic [31:0] ID_B = 32'h0140_0102;
    localparam logic [31:0] ID_C = 32'h0178_0203;
    localparam logic [31:0] ID_D = 32'h0190_0304;
    localparam logic [31:0] PROC = 32'h0C00_0191;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        card_present = 1'b0, card_wprot = 1'b0;
    logic        raw = 1'b0;
    logic [31:0] rd  [4];
    logic [7:0]  led [4];
    logic        rq  [4];
    logic [1:0]  mx  [4];

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    sysreg_bank #(.ID_VALUE(ID_A), .PROC_ID(PROC)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd[0]), .card_present(card_present),
        .card_wprot(card_wprot), .led_out(led[0]), .reset_req(rq[0]), .disp_mux(mx[0]));
    sysreg_bank #(.ID_VALUE(ID_B), .PROC_ID(PROC)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd[1]), .card_present(card_present),
        .card_wprot(card_wprot), .led_out(led[1]), .reset_req(rq[1]), .disp_mux(mx[1]));
    sysreg_bank #(.ID_VALUE(ID_C), .PROC_ID(PROC)) u2 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd[2]), .card_present(card_present),
        .card_wprot(card_wprot), .led_out(led[2]), .reset_req(rq[2]), .disp_mux(mx[2]));
    sysreg_bank #(.ID_VALUE(ID_D), .PROC_ID(PROC)) u3 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd[3]), .card_present(card_present),
        .card_wprot(card_wprot), .led_out(led[3]), .reset_req(rq[3]), .disp_mux(mx[3]));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_all(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd_all(input logic [11:0] a, input logic [31:0] e0, input logic [31:0] e1,
                          input logic [31:0] e2, input logic [31:0] e3, input string tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        sbq.push_back('{0, e0, tag});
        sbq.push_back('{1, e1, tag});
        sbq.push_back('{2, e2, tag});
        sbq.push_back('{3, e3, tag});
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_raw(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        raw = 1'b1; psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #2 v = rd[0];
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; raw = 1'b0;
    endtask

    task automatic chk_req(input bit e0, input bit e1, input bit e2, input bit e3, input string tag);
        check(32'(rq[0]), 32'(e0), tag);
        check(32'(rq[1]), 32'(e1), tag);
        check(32'(rq[2]), 32'(e2), tag);
        check(32'(rq[3]), 32'(e3), tag);
    endtask

    task automatic chk_mux(input logic [1:0] e0, input string tag);
        check(32'(mx[0]), 32'(e0), tag);
        check(32'(mx[1]), 32'h0, tag);
        check(32'(mx[2]), 32'h0, tag);
        check(32'(mx[3]), 32'h0, tag);
    endtask

    // Monitor: pops expected words and compares them in the access phase.
    always @(negedge clk) begin
        #1;
        if (psel && penable && !pwrite && !raw && sbq.size() >= 4) begin
            for (int k = 0; k < 4; k++) begin
                item_t it;
                it = sbq.pop_front();
                check(rd[it.idx], it.exp, $sformatf("%s u%0d", it.tag, it.idx));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 fixed and identity words, R5 reset state, R9 display reset values
        rd_all(12'h000, ID_A, ID_B, ID_C, ID_D, "R1 id");
        rd_all(12'h084, PROC, PROC, PROC, PROC, "R1 proc");
        rd_all(12'h044, 1, 1, 1, 1, "R1 one");
        rd_all(12'h088, 32'hFF000000, 32'hFF000000, 32'hFF000000, 32'hFF000000, "R1 fixed");
        rd_all(12'h050, 32'h1F00, 32'h1F00, 32'h1F00, 0, "R9 disp reset");
        rd_all(12'h008, 0, 0, 0, 0, "R5 led reset");
        rd_all(12'h020, 0, 0, 0, 0, "R5 key reset");
        rd_all(12'h030, 0, 0, 0, 0, "R5 flags reset");
        chk_mux(2'b00, "R5 mux reset");

        // R6 LEDs
        wr_all(12'h008, 32'h0000_01A5);
        rd_all(12'h008, 32'hA5, 32'hA5, 32'hA5, 32'hA5, "R6 led read");
        check(32'(led[0]), 32'hA5, "R6 led_out");

        // R3 user flags
        wr_all(12'h030, 32'h0000_00F0);
        wr_all(12'h030, 32'h0000_0F00);
        rd_all(12'h030, 32'hFF0, 32'hFF0, 32'hFF0, 32'hFF0, "R3 set");
        wr_all(12'h034, 32'h0000_0330);
        rd_all(12'h030, 32'hCC0, 32'hCC0, 32'hCC0, 32'hCC0, "R3 clear");

        // R4 retained flags
        wr_all(12'h03C, 32'hFFFF_FFFF);
        wr_all(12'h038, 32'h8000_0001);
        rd_all(12'h038, 32'h80000001, 32'h80000001, 32'h80000001, 32'h80000001, "R4 set");
        wr_all(12'h03C, 32'h0000_0010);
        rd_all(12'h038, 32'h80000001, 32'h80000001, 32'h80000001, 32'h80000001, "R4 clr none");

        // R7 locked write ignored
        wr_all(12'h040, 32'h0000_0104);
        chk_req(0, 0, 0, 0, "R7 locked no req");
        rd_all(12'h040, 0, 0, 0, 0, "R7 locked");

        // R2 key handling
        wr_all(12'h020, 32'h1234_F00D);
        rd_all(12'h020, 32'h700D, 32'h700D, 32'h700D, 32'h700D, "R2 bit15 cleared");
        wr_all(12'h020, 32'h0000_A05F);
        rd_all(12'h020, 32'hA05F, 32'hA05F, 32'hA05F, 32'hA05F, "R2 key stored");

        // R7 R8 unlocked reset control
        wr_all(12'h040, 32'h0000_0104);
        chk_req(1, 0, 1, 0, "R8 pulse high");
        @(negedge clk);
        chk_req(0, 0, 0, 0, "R8 pulse one cycle");
        rd_all(12'h040, 32'h104, 0, 32'h104, 0, "R7 stored");
        wr_all(12'h040, 32'h0000_0004);
        chk_req(0, 0, 1, 0, "R8 trigger bit");
        rd_all(12'h040, 32'h4, 0, 32'h4, 0, "R7 second");

        // R2 relock with another value
        wr_all(12'h020, 32'h0000_A05E);
        rd_all(12'h020, 32'h205E, 32'h205E, 32'h205E, 32'h205E, "R2 relock value");
        wr_all(12'h040, 32'h0000_0104);
        chk_req(0, 0, 0, 0, "R2 relocked no req");
        rd_all(12'h040, 32'h4, 0, 32'h4, 0, "R2 relocked");

        // R10 R11 R12 R9 display word
        wr_all(12'h050, 32'hFFFF_C0F6);
        chk_mux(2'b10, "R11 mux first");
        rd_all(12'h050, 32'hFFFFDFF6, 32'hFFFFDFF6, 32'hFFFFC076, 0, "R10 R12 disp write");
        wr_all(12'h050, 32'h0000_0001);
        chk_mux(2'b01, "R11 mux second");
        rd_all(12'h050, 32'h1F01, 32'h1F01, 32'h1, 0, "R10 R12 disp second");

        // R13 card status
        card_present = 1'b1; card_wprot = 1'b1;
        rd_all(12'h048, 5, 5, 3, 3, "R13 both");
        card_present = 1'b0;
        rd_all(12'h048, 4, 4, 2, 2, "R13 wprot only");
        wr_all(12'h048, 32'hFFFF_FFFF);
        rd_all(12'h048, 4, 4, 2, 2, "R13 write ignored");

        // R1 unmapped and fixed words ignore writes
        wr_all(12'h100, 32'hFFFF_FFFF);
        rd_all(12'h100, 0, 0, 0, 0, "R1 unmapped");
        rd_all(12'h004, 0, 0, 0, 0, "R1 hole");
        wr_all(12'h044, 32'h0);
        rd_all(12'h044, 1, 1, 1, 1, "R1 fixed write");

        // R14 tick counter across exactly 100 cycles
        rd_raw(12'h05C, t0);
        repeat (97) @(negedge clk);
        rd_raw(12'h05C, t1);
        check(t1 - t0, 32'd24, "R14 tick rate");

        // R5 reset behaviour, R4 retention
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_all(12'h008, 0, 0, 0, 0, "R5 led cleared");
        check(32'(led[0]), 32'h0, "R5 led_out cleared");
        rd_all(12'h020, 0, 0, 0, 0, "R5 key cleared");
        rd_all(12'h030, 0, 0, 0, 0, "R5 flags cleared");
        rd_all(12'h040, 0, 0, 0, 0, "R5 rstctl cleared");
        rd_all(12'h050, 32'h1F00, 32'h1F00, 32'h1F00, 0, "R5 disp reset");
        chk_mux(2'b00, "R5 mux cleared");
        rd_all(12'h038, 32'h80000001, 32'h80000001, 32'h80000001, 32'h80000001, "R4 kept over reset");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule